// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer with Reading Hold

This block is the digital controller of a dual-slope integrating analog-to-digital converter. It runs from the oscillator clock and internally derives a count strobe once every four oscillator cycles. Every conversion passes through three phases, in order: offset cancellation (auto-zero), a fixed-length integration of the input, and a de-integration against a reference of opposite sign. The block drives one enable per phase, so that external analog switches can be set, and it picks the sign of the reference.

During de-integration a four-decade BCD counter counts strobes until the comparator reports that the integrator has returned to zero. That count is the reading: 1000 counts correspond to an input equal to the reference. The reading, its sign and an over-range flag go into an output latch at the end of de-integration. A hold input freezes that latch while conversions keep running. Auto-zero takes whatever part of the de-integration window was not used, so every conversion has the same length.

Top module: `dual_slope_seq`

## Requirements
- R1: All sequencing advances only on a count strobe that occurs once every 4 oscillator cycles, so each phase lasts a whole multiple of 4 `clk_i` cycles.
- R2: While `rst_ni` is low and after it is released, only `az_en_o` is high, `ref_neg_o` is low and all reading outputs are zero. The first auto-zero lasts 1000 counts, so `int_en_o` first rises 4000 cycles after release.
- R3: Exactly one of `az_en_o`, `int_en_o`, `de_en_o` is high at any time, and the phases run in the order auto-zero, integrate, de-integrate, then repeat.
- R4: The integrate phase lasts exactly 1000 counts.
- R5: `cmp_i` high means the integrator output is above zero. Its value at the last integrate count is stored as the integration sign. De-integration ends at the first count at which `cmp_i` differs from that stored sign. The reading is the number of counts that came before that count, so a reading of N gives a de-integrate phase of N+1 counts.
- R6: From one rise of `int_en_o` to the next there are always 4000 counts (16000 `clk_i` cycles), whatever the reading.
- R7: `neg_o` is latched as 1 when the stored integration sign is low (negative input). `ref_neg_o` is 1 during de-integration when the stored sign is high, 0 when it is low, and 0 outside de-integration.
- R8: The reading appears as BCD digits on `ones_o`, `tens_o`, `hund_o` (4 bits each, value 0-9), and `thou_o` is 1 for readings of 1000 or more.
- R9: If the comparator has not changed by the 2000th de-integrate count, de-integration ends at that count and the latch is loaded with `over_o`=1 and the reading 1999 (`thou_o`=1, digits 9,9,9).
- R10: If `cmp_i` already differs from the stored sign at the first de-integrate count, the latched reading is 000 with the sampled polarity on `neg_o` and `over_o`=0.
- R11: When `hold_i` is high at the count that ends de-integration, the reading outputs keep their previous values while conversions continue. The next conversion that ends with `hold_i` low loads its new result.
- R12: The reading outputs change only on the clock edge that ends de-integration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_i | input | 1 | Comparator: 1 when the integrator output is above zero |
| hold_i | input | 1 | 1 blocks loading of the reading latch |
| az_en_o | output | 1 | Auto-zero phase enable |
| int_en_o | output | 1 | Signal-integrate phase enable |
| de_en_o | output | 1 | De-integrate phase enable |
| ref_neg_o | output | 1 | 1 selects the negative reference during de-integration |
| ones_o | output | 4 | Latched units digit, BCD |
| tens_o | output | 4 | Latched tens digit, BCD |
| hund_o | output | 4 | Latched hundreds digit, BCD |
| thou_o | output | 1 | Latched thousands flag |
| neg_o | output | 1 | Latched polarity, 1 = negative input |
| over_o | output | 1 | Latched over-range flag |

## Verification
The bench models the integrator as a comparator that changes a chosen number of counts into de-integration. It targets a zero reading, whose comparator has already changed at the first count; a design that counted one strobe early or late would latch 001 or lose the polarity bit. It also targets 1999 and an input that never returns to zero. A design that confused these two would latch the wrong value or stretch de-integration past 2000 counts, and then the 4000-count cycle length would be broken. Separate scenarios check carries across decades (1000), a held conversion followed by a released one, and the sign of the reference for both input polarities.

// File: rtl/dsq_pkg.sv
package dsq_pkg;

  typedef enum logic [1:0] {
    PH_AZ  = 2'd0,
    PH_INT = 2'd1,
    PH_DE  = 2'd2
  } phase_e;

  // Packs a non-negative integer into 16 BCD digits, units in the low nibble.
  function automatic logic [63:0] to_bcd(int unsigned v);
    logic [63:0] r;
    int unsigned x;
    r = '0;
    x = v;
    for (int i = 0; i < 16; i++) begin
      r[i*4 +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

endpackage

// File: rtl/dsq_tick_gen.sv
module dsq_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/dsq_bcd_cnt.sv
module dsq_bcd_cnt #(
  parameter int NDIG = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              inc_i,
  output logic [NDIG*4-1:0] digits_o
);
  logic [NDIG:0] carry;

  assign carry[0] = inc_i;

  for (genvar d = 0; d < NDIG; d++) begin : g_dig
    logic [3:0] dig_q;

    assign carry[d+1]        = carry[d] && (dig_q == 4'd9);
    assign digits_o[d*4 +: 4] = dig_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       dig_q <= '0;
      else if (clr_i)    dig_q <= '0;
      else if (carry[d]) dig_q <= (dig_q == 4'd9) ? 4'd0 : dig_q + 4'd1;
    end
  end
endmodule

// File: rtl/dsq_ctrl.sv
module dsq_ctrl
  import dsq_pkg::*;
#(
  parameter int INT_CNT = 1000,
  parameter int DE_MAX  = 2000,
  parameter int CYCLE   = 4000
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   tick_i,
  input  logic   cmp_i,
  input  logic   full_i,
  output phase_e phase_o,
  output logic   integ_pos_o,
  output logic   cnt_clr_o,
  output logic   cnt_inc_o,
  output logic   done_o,
  output logic   over_o
);
  localparam int TW = $clog2(CYCLE);
  localparam logic [TW-1:0] TOT_LAST = TW'(CYCLE - 1);
  localparam logic [TW-1:0] INT_LAST = TW'(INT_CNT - 1);
  // reset as if a full-length de-integrate just ended
  localparam logic [TW-1:0] TOT_RST  = TW'(INT_CNT + DE_MAX);

  phase_e        ph_q;
  logic [TW-1:0] tot_q;
  logic          pos_q;
  logic          trip;
  logic          int_end;

  assign trip    = (cmp_i != pos_q);
  assign int_end = (ph_q == PH_INT) && tick_i && (tot_q == INT_LAST);
  assign done_o  = (ph_q == PH_DE) && tick_i && (trip || full_i);
  assign over_o  = done_o && !trip;

  assign cnt_clr_o   = int_end;
  assign cnt_inc_o   = (ph_q == PH_DE) && tick_i && !done_o;
  assign phase_o     = ph_q;
  assign integ_pos_o = pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_AZ;
      tot_q <= TOT_RST;
      pos_q <= 1'b0;
    end else if (tick_i) begin
      tot_q <= (tot_q == TOT_LAST) ? '0 : tot_q + TW'(1);
      unique case (ph_q)
        PH_AZ:  if (tot_q == TOT_LAST) ph_q <= PH_INT;
        PH_INT: if (tot_q == INT_LAST) begin
                  ph_q  <= PH_DE;
                  pos_q <= cmp_i;
                end
        PH_DE:  if (trip || full_i) ph_q <= PH_AZ;
        default: ph_q <= PH_AZ;
      endcase
    end
  end
endmodule

// File: rtl/dual_slope_seq.sv
module dual_slope_seq
  import dsq_pkg::*;
#(
  parameter int DIV     = 4,
  parameter int INT_CNT = 1000,
  parameter int DE_MAX  = 2000,
  parameter int CYCLE   = 4000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmp_i,
  input  logic       hold_i,
  output logic       az_en_o,
  output logic       int_en_o,
  output logic       de_en_o,
  output logic       ref_neg_o,
  output logic [3:0] ones_o,
  output logic [3:0] tens_o,
  output logic [3:0] hund_o,
  output logic       thou_o,
  output logic       neg_o,
  output logic       over_o
);
  localparam int NDIG = 4;
  localparam logic [63:0] FULL_ALL = to_bcd(DE_MAX - 1);
  localparam logic [NDIG*4-1:0] FULL_BCD = FULL_ALL[NDIG*4-1:0];

  logic              tick;
  logic              full;
  logic              integ_pos;
  logic              cnt_clr, cnt_inc, done, over_now;
  phase_e            phase;
  logic [NDIG*4-1:0] dig;

  dsq_tick_gen #(.DIV(DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  dsq_ctrl #(
    .INT_CNT(INT_CNT),
    .DE_MAX (DE_MAX),
    .CYCLE  (CYCLE)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .cmp_i      (cmp_i),
    .full_i     (full),
    .phase_o    (phase),
    .integ_pos_o(integ_pos),
    .cnt_clr_o  (cnt_clr),
    .cnt_inc_o  (cnt_inc),
    .done_o     (done),
    .over_o     (over_now)
  );

  dsq_bcd_cnt #(.NDIG(NDIG)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (cnt_clr),
    .inc_i   (cnt_inc),
    .digits_o(dig)
  );

  assign full = (dig == FULL_BCD);

  assign az_en_o   = (phase == PH_AZ);
  assign int_en_o  = (phase == PH_INT);
  assign de_en_o   = (phase == PH_DE);
  assign ref_neg_o = de_en_o && integ_pos;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ones_o <= '0;
      tens_o <= '0;
      hund_o <= '0;
      thou_o <= 1'b0;
      neg_o  <= 1'b0;
      over_o <= 1'b0;
    end else if (done && !hold_i) begin
      ones_o <= dig[3:0];
      tens_o <= dig[7:4];
      hund_o <= dig[11:8];
      thou_o <= |dig[15:12];
      neg_o  <= !integ_pos;
      over_o <= over_now;
    end
  end
endmodule

// File: rtl/dual_slope_seq_chk.sv
module dual_slope_seq_chk #(
  parameter int DIV     = 4,
  parameter int INT_CNT = 1000
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmp_i,
  input logic       hold_i,
  input logic       az_en_o,
  input logic       int_en_o,
  input logic       de_en_o,
  input logic       ref_neg_o,
  input logic [3:0] ones_o,
  input logic [3:0] tens_o,
  input logic [3:0] hund_o,
  input logic       thou_o,
  input logic       neg_o,
  input logic       over_o
);
  logic [14:0] rd;
  logic [31:0] int_cyc;
  logic        unused_cmp;

  assign rd         = {over_o, neg_o, thou_o, hund_o, tens_o, ones_o};
  assign unused_cmp = cmp_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       int_cyc <= '0;
    else if (int_en_o) int_cyc <= int_cyc + 32'd1;
    else               int_cyc <= '0;
  end

  // R3
  one_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({az_en_o, int_en_o, de_en_o}) == 1);

  // R3
  int_after_az_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(int_en_o) |-> $past(az_en_o));

  // R3
  de_after_int_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(de_en_o) |-> $past(int_en_o));

  // R3
  az_after_de_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(az_en_o) |-> $past(de_en_o));

  // R4
  int_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(int_en_o) |-> (int_cyc == 32'(INT_CNT * DIV)));

  // R7
  ref_in_de_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_neg_o |-> de_en_o);

  // R9
  over_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    over_o |-> (thou_o && hund_o == 4'd9 && tens_o == 4'd9 && ones_o == 4'd9));

  // R11
  hold_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(hold_i) |-> $stable(rd));

  // R12
  load_at_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rd) |-> $fell(de_en_o));
endmodule

bind dual_slope_seq dual_slope_seq_chk #(.DIV(DIV), .INT_CNT(INT_CNT)) u_chk (.*);

// File: tb/dual_slope_seq_test.sv
`timescale 1ns/1ps
module dual_slope_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmp;
  logic       hold = 1'b0;
  logic       az_en, int_en, de_en, ref_neg;
  logic [3:0] ones, tens, hund;
  logic       thou, neg, over;

  int  checks = 0;
  int  fails = 0;
  bit  done = 1'b0;
  int  stim_n = 0;
  bit  stim_neg = 1'b0;
  int  m = 0;
  int  cyc = 0;
  int  last_rise = 0;
  int  int_run = 0;
  bit  seen_int = 1'b0;
  bit  int_prev = 1'b0;
  bit  de_prev = 1'b0;
  logic [14:0] last_rd = '0;

  typedef struct {
    logic [14:0] rd;
    int          len;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  // integrator model: polarity during integrate, crosses zero after stim_n counts
  assign cmp = de_en ? ((!stim_neg) ^ (m >= 4 * stim_n)) : !stim_neg;

  dual_slope_seq uut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .cmp_i    (cmp),
    .hold_i   (hold),
    .az_en_o  (az_en),
    .int_en_o (int_en),
    .de_en_o  (de_en),
    .ref_neg_o(ref_neg),
    .ones_o   (ones),
    .tens_o   (tens),
    .hund_o   (hund),
    .thou_o   (thou),
    .neg_o    (neg),
    .over_o   (over)
  );

  function automatic logic [14:0] pack_rd(int v, bit n, bit o);
    return {o, n, (v >= 1000), 4'((v / 100) % 10), 4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic run_conv(input int n, input bit ng, input bit hld, input string tag);
    exp_t it;
    int   v;
    bit   o;
    @(negedge clk);
    while (!int_en) @(negedge clk);
    stim_n   = n;
    stim_neg = ng;
    hold     = hld;
    o = (n >= 2000);
    v = o ? 1999 : n;
    if (!hld) last_rd = pack_rd(v, ng, o);
    it.rd  = last_rd;
    it.len = o ? 8000 : 4 * (n + 1);
    it.tag = tag;
    q.push_back(it);
    while (int_en) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (int_en && !int_prev) begin
        if (!seen_int) chk(cyc == 4000, "R2 first auto-zero", cyc, 4000);
        else           chk(cyc - last_rise == 16000, "R6 cycle length", cyc - last_rise, 16000);
        seen_int  = 1'b1;
        last_rise = cyc;
        int_run   = 0;
      end
      if (int_en) int_run++;
      if (!int_en && int_prev) chk(int_run == 4000, "R1 R4 integrate length", int_run, 4000);
      if (de_en && !de_prev) begin
        m = 0;
        chk(ref_neg == !stim_neg, "R7 reference sign", ref_neg, !stim_neg);
      end else if (de_en) begin
        m++;
      end
      if (!de_en && de_prev) begin
        if (q.size() == 0) begin
          chk(1'b0, "R12 unexpected conversion end", 0, 1);
        end else begin
          exp_t it;
          it = q.pop_front();
          chk(m + 1 == it.len, {it.tag, " R5 de-integrate length"}, m + 1, it.len);
          chk({over, neg, thou, hund, tens, ones} == it.rd, {it.tag, " reading"},
              {over, neg, thou, hund, tens, ones}, it.rd);
        end
      end
      int_prev = int_en;
      de_prev  = de_en;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(az_en && !int_en && !de_en, "R2 phase in reset", {az_en, int_en, de_en}, 3'b100);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(az_en && !int_en && !de_en && !ref_neg, "R2 phase after reset",
        {az_en, int_en, de_en, ref_neg}, 4'b1000);
    chk({over, neg, thou, hund, tens, ones} == 15'd0, "R2 reading after reset",
        {over, neg, thou, hund, tens, ones}, 0);

    run_conv(123,  1'b0, 1'b0, "R8 mid reading");
    run_conv(0,    1'b1, 1'b0, "R10 zero reading");
    run_conv(1999, 1'b0, 1'b0, "R8 full reading");
    run_conv(2500, 1'b1, 1'b0, "R9 over-range");
    run_conv(456,  1'b0, 1'b1, "R11 held");
    run_conv(789,  1'b1, 1'b0, "R11 resumed");
    run_conv(1000, 1'b0, 1'b0, "R8 thousands carry");
    run_conv(1,    1'b1, 1'b0, "R5 one count");

    while (q.size() != 0) @(negedge clk);
    repeat (8) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule